// File: doc/BRIEF.md
# Dual-Rate Reference Strobe Divider

This block turns a reference clock into the comparison-rate strobes for two phase-locked loops. One down-scaling counter, set by a 12-bit ratio, defines the period. Loop A gets a single-cycle strobe when the counter wraps. Loop B gets its strobe at the counter's half-way point. The two loops therefore see their active edges half an output period apart, and their charge pumps never fire together.

A rate-select input chooses how often loop B fires. It can fire at every half-way point, so it runs at loop A's rate. It can also fire at every other half-way point, so it runs at half that rate, through a toggle stage. A new ratio is only picked up when the count wraps. A restart input puts the counter and the toggle back to a known phase, so the loops come back from power-down without a random phase step.

Top module: `ref_div_dual`

## Requirements
- R1: With effective ratio N, `strobe_a` goes high N clock cycles after reset or restart is released and then once every N cycles, for exactly one cycle each time.
- R2: With `half_sel` = 0, `strobe_b` goes high floor(N/2) cycles after release and then once every N cycles, for one cycle each time.
- R3: With `half_sel` = 1, `strobe_b` goes high floor(N/2)+N cycles after release and then once every 2N cycles, for one cycle each time.
- R4: `strobe_a` and `strobe_b` are never high in the same cycle.
- R5: A `ratio` value below 8 (0 through 7) behaves exactly as ratio 8. Values from 8 to 4095 are used as given.
- R6: A `ratio` change during a count does not shorten or lengthen that count. It is loaded when the count wraps, and both strobes follow the new ratio from then on.
- R7: `restart` high at a rising edge clears the count and the half-rate toggle and loads the current ratio. Both strobes are low in the following cycle, and the timing of R1 to R3 starts again from that edge.
- R8: While `rst_n` is low at the rising edges, both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio | input | 12 | Programmed division ratio |
| half_sel | input | 1 | 1 makes loop B run at half loop A's rate |
| restart | input | 1 | Synchronous phase restart |
| strobe_a | output | 1 | Loop A comparison strobe |
| strobe_b | output | 1 | Loop B comparison strobe |

## Verification
The assertions check four properties on every cycle. The two strobes never overlap. Each strobe lasts exactly one cycle. A restart silences both strobes in the next cycle. Loop A's strobes are never closer together than the minimum ratio. The exact phase placement of each strobe can only be shown by the bench's scenarios: the half-way offset of loop B, the every-other-time pattern in half-rate mode, clamping of small ratios, and a ratio change that is deferred to the wrap.

// File: rtl/ref_div_dual.sv
module ref_div_dual #(
  parameter int RW   = 12,
  parameter int RMIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  input  logic          half_sel,
  input  logic          restart,
  output logic          strobe_a,
  output logic          strobe_b
);

  localparam logic [RW-1:0] FLOOR = RW'(RMIN);

  logic [RW-1:0] cnt;
  logic [RW-1:0] lat;
  logic          tog;

  wire [RW-1:0] ratio_eff = (ratio < FLOOR) ? FLOOR : ratio;
  wire [RW-1:0] last      = lat - 1'b1;
  wire [RW-1:0] mid_m1    = (lat >> 1) - 1'b1;
  wire          at_end    = (cnt == last);
  wire          at_mid    = (cnt == mid_m1);
  wire          clr       = !rst_n || restart;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt      <= '0;
      lat      <= ratio_eff;
      tog      <= 1'b0;
      strobe_a <= 1'b0;
      strobe_b <= 1'b0;
    end else begin
      strobe_a <= at_end;
      strobe_b <= at_mid && (!half_sel || tog);
      if (at_mid && half_sel) tog <= ~tog;
      if (at_end) begin
        cnt <= '0;
        lat <= ratio_eff;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ref_div_dual_chk.sv
module ref_div_dual_chk #(
  parameter int RW   = 12,
  parameter int RMIN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic strobe_a,
  input logic strobe_b
);

  logic [RW:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) gap <= '0;
    else if (strobe_a)     gap <= (RW+1)'(1);
    else if (gap != '1)    gap <= gap + 1'b1;
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_a && strobe_b));

  // R1
  a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a |=> !strobe_a);

  // R2 R3
  b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_b |=> !strobe_b);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!strobe_a && !strobe_b));

  // R5
  min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a |-> (gap >= (RW+1)'(RMIN)));

endmodule

bind ref_div_dual ref_div_dual_chk #(.RW(RW), .RMIN(RMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart),
  .strobe_a(strobe_a), .strobe_b(strobe_b)
);

// File: tb/tb_ref_div_dual.sv
module tb_ref_div_dual;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {half_sel, ratio}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 12'd8},  {1'b1, 12'd8},  {1'b0, 12'd9},   {1'b1, 12'd13},
    {1'b0, 12'd100},{1'b0, 12'd3},  {1'b1, 12'd0},   {1'b1, 12'd4095}
  };

  logic clk = 0, rst_n = 0, half_sel = 0, restart = 0;
  logic [11:0] ratio = 12'd10;
  logic strobe_a, strobe_b;
  int checks = 0, errors = 0;
  bit done = 0;

  ref_div_dual dut (.clk(clk), .rst_n(rst_n), .ratio(ratio), .half_sel(half_sel),
                    .restart(restart), .strobe_a(strobe_a), .strobe_b(strobe_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  function automatic bit exp_a(int n, int k);
    return k > 0 && (k % n) == 0;
  endfunction

  function automatic bit exp_b(int n, bit h, int k);
    int m = n / 2;
    if (k < m) return 0;
    if (!h) return ((k - m) % n) == 0;
    return ((k - m) % (2 * n)) == n;
  endfunction

  task automatic do_restart(input logic [11:0] r, input logic h);
    @(negedge clk);
    ratio = r; half_sel = h; restart = 1;
    @(posedge clk);
    @(negedge clk);
    restart = 0;
    chk("R7", strobe_a | strobe_b, 1'b0, 0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    ratio = 12'd10; half_sel = 0; rst_n = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8", strobe_a | strobe_b, 1'b0, i);
    end
    rst_n = 1;
    // R1 R2 after reset release, ratio 10
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      chk("R1", strobe_a, exp_a(10, k), k);
      chk("R2", strobe_b, exp_b(10, 0, k), k);
    end

    // table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      logic h;
      int n, r;
      h = VEC[v][12];
      r = int'(VEC[v][11:0]);
      n = (r < 8) ? 8 : r;
      do_restart(VEC[v][11:0], h);
      for (int k = 1; k <= 4 * n + 2; k++) begin
        @(negedge clk);
        chk(r < 8 ? "R5" : "R1", strobe_a, exp_a(n, k), k);
        chk(h ? "R3" : "R2", strobe_b, exp_b(n, h, k), k);
        chk("R4", strobe_a & strobe_b, 1'b0, k);
      end
    end

    // R6: ratio change mid-count applies at the wrap
    do_restart(12'd10, 1'b0);
    for (int k = 1; k <= 42; k++) begin
      @(negedge clk);
      if (k == 3) ratio = 12'd20;
      chk("R6", strobe_a, (k == 10 || k == 30), k);
      chk("R6", strobe_b, (k == 5 || k == 20 || k == 40), k);
    end

    // R7: restart in the middle of a half-rate run
    do_restart(12'd12, 1'b1);
    for (int k = 1; k <= 7; k++) @(negedge clk);
    do_restart(12'd12, 1'b1);
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      chk("R7", strobe_a, exp_a(12, k), k);
      chk("R7", strobe_b, exp_b(12, 1, k), k);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule